// File: doc/BRIEF.md
# Instruction Word Decoder and Phase Sequencer

This block sits between a host port and a rational-number arithmetic datapath. It turns a 32-bit instruction word into one enable line per operation and into three register numbers, one for each bus: two read buses (A and B) and one write bus (C). It also produces a repeating four-phase timing pattern. Each instruction moves through its stages in that pattern: phase 1 latches the register outputs, phase 2 clocks the arithmetic unit, phase 3 clocks the register write, and phase 4 closes the period.

A new word is taken only when a period ends, and only if the host strobe is high at that point. The decoded result is then held for the whole of the next period. A busy indication from the arithmetic unit stretches phase 2 for as long as it lasts. Words that cannot be decoded behave as a no-operation and raise an error flag for that period.

Top module: `cw_sequencer`

## Requirements
- R1: While reset is high and right after it, phase 1 alone is active, and every enable, select, register number and the illegal flag is zero.
- R2: Exactly one phase line is high in every cycle. Without a hold, the phases advance 1→2→3→4→1 on successive clocks, with phase[0] as phase 1.
- R3: If unit_busy is high at a clock edge while phase 2 is active, phase 2 stays active. It advances on the first edge with unit_busy low. Busy has no effect in any other phase.
- R4: The word is captured only at the clock edge that leaves phase 4, and only if host_strobe is high at that edge. All decoded outputs then stay constant for the four phases that follow. Strobes and word changes in phases 1 to 3 have no effect.
- R5: If host_strobe is low at the edge that leaves phase 4, the next period is idle. No enable or select is high, all register numbers are zero and the illegal flag is low.
- R6: The opcode is in bits 23:16 and turns on exactly one enable bit. The mapping is 0x04→op_en[0], 0x08→[1], 0x0C→[2], 0x10→[3], 0x18→[4], 0x1C→[5], 0x30→[6], 0x34→[7], 0x38→[8], 0x3C→[9].
- R7: Register numbers come from fixed fields of the word: the A bus from bits 3:0, the B bus from bits 7:4 and the C bus from bits 11:8.
- R8: Select lines follow what each operation uses. op_en[0], [2], [6] and [7] use A and C. op_en[1], [3], [4] and [5] use A, B and C. op_en[8] uses C only, and op_en[9] uses A only. The register number of an unused bus reads zero.
- R9: A word is illegal if its opcode is not listed, or if bits 31:24 or bits 15:12 are nonzero. An illegal word gives a no-operation period with illegal_op high for that whole period.
- R10: Opcode 0x00 with zero reserved bits is a legal no-operation. No enable or select is high, and illegal_op is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_strobe | input | 1 | Host offers a word for the next period |
| unit_busy | input | 1 | Arithmetic unit requests that phase 2 be stretched |
| ctrl_word | input | 32 | Instruction word |
| op_en | output | 10 | One-hot operation enables |
| a_sel | output | 1 | A bus in use |
| b_sel | output | 1 | B bus in use |
| c_sel | output | 1 | C bus in use |
| a_reg | output | 4 | A bus register number |
| b_reg | output | 4 | B bus register number |
| c_reg | output | 4 | C bus register number |
| illegal_op | output | 1 | Word of this period could not be decoded |
| phase | output | 4 | One-hot phase lines, bit 0 = phase 1 |

## Verification
A stretch of phase 2 and a host strobe carrying a different word can occur in the same cycle. The bench provokes this by raising unit_busy and host_strobe together for several cycles in phase 2, with a new word on the bus. It then judges that the phase line stays on phase 2 and that the decoded outputs keep the instruction that was captured at the previous phase-4 boundary. A scoreboard checks every phase transition against the rule derived from the busy level it observed. It also compares every output sample with the item that the driver queued when it offered that word.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    localparam int CW_W       = 32;
    localparam int REG_AW     = 4;
    localparam int OPC_W      = 8;
    localparam int OPC_LSB    = 16;
    localparam int RSV_HI_LSB = OPC_LSB + OPC_W;
    localparam int RSV_HI_W   = CW_W - RSV_HI_LSB;
    localparam int A_LSB      = 0;
    localparam int B_LSB      = A_LSB + REG_AW;
    localparam int C_LSB      = B_LSB + REG_AW;
    localparam int RSV_LO_LSB = C_LSB + REG_AW;
    localparam int RSV_LO_W   = OPC_LSB - RSV_LO_LSB;
    localparam int NUM_OPS    = 10;
    localparam int NUM_PHASES = 4;
    localparam int PH_CNT_W   = $clog2(NUM_PHASES);
    localparam int HOLD_PHASE = 1;

    typedef enum logic [3:0] {
        OP_GCD   = 4'd0,
        OP_CAST  = 4'd1,
        OP_SWAP  = 4'd2,
        OP_MUL   = 4'd3,
        OP_ADD   = 4'd4,
        OP_SUB   = 4'd5,
        OP_MOVE  = 4'd6,
        OP_COPY  = 4'd7,
        OP_LOAD  = 4'd8,
        OP_STORE = 4'd9,
        OP_NONE  = 4'd15
    } op_idx_e;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } bus_use_t;

    typedef struct packed {
        op_idx_e op;
        logic    known;
    } lookup_t;

    typedef struct packed {
        logic [NUM_OPS-1:0] en;
        bus_use_t           bus;
        logic [REG_AW-1:0]  a_reg;
        logic [REG_AW-1:0]  b_reg;
        logic [REG_AW-1:0]  c_reg;
        logic               illegal;
    } instr_t;

    localparam instr_t INSTR_IDLE = '0;

    function automatic lookup_t opcode_lookup(input logic [OPC_W-1:0] opc);
        lookup_t r;
        r.known = 1'b1;
        unique case (opc)
            8'h00:   r.op = OP_NONE;
            8'h04:   r.op = OP_GCD;
            8'h08:   r.op = OP_CAST;
            8'h0C:   r.op = OP_SWAP;
            8'h10:   r.op = OP_MUL;
            8'h18:   r.op = OP_ADD;
            8'h1C:   r.op = OP_SUB;
            8'h30:   r.op = OP_MOVE;
            8'h34:   r.op = OP_COPY;
            8'h38:   r.op = OP_LOAD;
            8'h3C:   r.op = OP_STORE;
            default: begin
                r.op    = OP_NONE;
                r.known = 1'b0;
            end
        endcase
        return r;
    endfunction

    function automatic bus_use_t bus_usage(input op_idx_e op);
        bus_use_t u;
        case (op)
            OP_CAST, OP_MUL, OP_ADD, OP_SUB:   u = '{a: 1'b1, b: 1'b1, c: 1'b1};
            OP_GCD, OP_SWAP, OP_MOVE, OP_COPY: u = '{a: 1'b1, b: 1'b0, c: 1'b1};
            OP_LOAD:                           u = '{a: 1'b0, b: 1'b0, c: 1'b1};
            OP_STORE:                          u = '{a: 1'b1, b: 1'b0, c: 1'b0};
            default:                           u = '{a: 1'b0, b: 1'b0, c: 1'b0};
        endcase
        return u;
    endfunction

endpackage

// File: rtl/cw_phase_gen.sv
module cw_phase_gen
    import cwd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  unit_busy,
    output logic [NUM_PHASES-1:0] phase,
    output logic                  period_end
);

    localparam logic [PH_CNT_W-1:0] LAST_CNT = PH_CNT_W'(NUM_PHASES - 1);
    localparam logic [PH_CNT_W-1:0] HOLD_CNT = PH_CNT_W'(HOLD_PHASE);

    logic [PH_CNT_W-1:0] cnt_q;
    logic                stall;

    assign stall      = (cnt_q == HOLD_CNT) && unit_busy;
    assign period_end = (cnt_q == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!stall) begin
            cnt_q <= period_end ? '0 : cnt_q + 1'b1;
        end
    end

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        assign phase[p] = (cnt_q == PH_CNT_W'(p));
    end

endmodule

// File: rtl/cw_field_decode.sv
module cw_field_decode
    import cwd_pkg::*;
(
    input  logic [CW_W-1:0] word,
    output instr_t          dec
);

    logic [OPC_W-1:0]   opc;
    logic               rsv_clear;
    lookup_t            look;
    logic               legal;
    bus_use_t           used;
    logic [NUM_OPS-1:0] en_vec;

    assign opc       = word[OPC_LSB +: OPC_W];
    assign rsv_clear = (word[RSV_HI_LSB +: RSV_HI_W] == '0) &&
                       (word[RSV_LO_LSB +: RSV_LO_W] == '0);
    assign look      = opcode_lookup(opc);
    assign legal     = look.known && rsv_clear;
    assign used      = legal ? bus_usage(look.op) : '0;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_en
        assign en_vec[i] = legal && (look.op == op_idx_e'(i));
    end

    always_comb begin
        dec         = INSTR_IDLE;
        dec.en      = en_vec;
        dec.bus     = used;
        dec.a_reg   = used.a ? word[A_LSB +: REG_AW] : '0;
        dec.b_reg   = used.b ? word[B_LSB +: REG_AW] : '0;
        dec.c_reg   = used.c ? word[C_LSB +: REG_AW] : '0;
        dec.illegal = !legal;
    end

endmodule

// File: rtl/cw_instr_latch.sv
module cw_instr_latch
    import cwd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   period_end,
    input  logic   host_strobe,
    input  instr_t dec,
    output instr_t held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= INSTR_IDLE;
        end else if (period_end) begin
            held <= host_strobe ? dec : INSTR_IDLE;
        end
    end

endmodule

// File: rtl/cw_sequencer.sv
module cw_sequencer
    import cwd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_strobe,
    input  logic                  unit_busy,
    input  logic [CW_W-1:0]       ctrl_word,
    output logic [NUM_OPS-1:0]    op_en,
    output logic                  a_sel,
    output logic                  b_sel,
    output logic                  c_sel,
    output logic [REG_AW-1:0]     a_reg,
    output logic [REG_AW-1:0]     b_reg,
    output logic [REG_AW-1:0]     c_reg,
    output logic                  illegal_op,
    output logic [NUM_PHASES-1:0] phase
);

    logic   period_end;
    instr_t dec;
    instr_t held;

    cw_phase_gen u_phase (
        .clk        (clk),
        .rst        (rst),
        .unit_busy  (unit_busy),
        .phase      (phase),
        .period_end (period_end)
    );

    cw_field_decode u_decode (
        .word (ctrl_word),
        .dec  (dec)
    );

    cw_instr_latch u_latch (
        .clk         (clk),
        .rst         (rst),
        .period_end  (period_end),
        .host_strobe (host_strobe),
        .dec         (dec),
        .held        (held)
    );

    assign op_en      = held.en;
    assign a_sel      = held.bus.a;
    assign b_sel      = held.bus.b;
    assign c_sel      = held.bus.c;
    assign a_reg      = held.a_reg;
    assign b_reg      = held.b_reg;
    assign c_reg      = held.c_reg;
    assign illegal_op = held.illegal;

endmodule

// File: rtl/cw_sequencer_checker.sv
module cw_sequencer_checker
    import cwd_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  host_strobe,
    input logic                  unit_busy,
    input logic [CW_W-1:0]       ctrl_word,
    input logic [NUM_OPS-1:0]    op_en,
    input logic                  a_sel,
    input logic                  b_sel,
    input logic                  c_sel,
    input logic [REG_AW-1:0]     a_reg,
    input logic [REG_AW-1:0]     b_reg,
    input logic [REG_AW-1:0]     c_reg,
    input logic                  illegal_op,
    input logic [NUM_PHASES-1:0] phase
);

    a_r2_phase_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);

    a_r2_first_step: assert property (@(posedge clk) disable iff (rst)
        phase[0] |=> phase[1]);

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        phase[NUM_PHASES-1] |=> phase[0]);

    a_r3_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (phase[HOLD_PHASE] && unit_busy) |=> phase[HOLD_PHASE]);

    a_r3_release: assert property (@(posedge clk) disable iff (rst)
        (phase[HOLD_PHASE] && !unit_busy) |=> phase[HOLD_PHASE + 1]);

    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !phase[NUM_PHASES-1] |=> ($stable(op_en) && $stable(illegal_op) &&
                                 $stable({a_sel, b_sel, c_sel}) &&
                                 $stable({a_reg, b_reg, c_reg})));

    a_r6_enable_onehot0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_en));

    a_r8_store_select: assert property (@(posedge clk) disable iff (rst)
        op_en[9] |-> (a_sel && !b_sel && !c_sel));

    a_r8_unused_zero: assert property (@(posedge clk) disable iff (rst)
        ((!a_sel -> a_reg == '0) && (!b_sel -> b_reg == '0) && (!c_sel -> c_reg == '0)));

    a_r9_illegal_idle: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (op_en == '0 && !a_sel && !b_sel && !c_sel));

endmodule

bind cw_sequencer cw_sequencer_checker u_chk (.*);

// File: tb/test_cw_sequencer.sv
module test_cw_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_strobe = 1'b0;
    logic        unit_busy = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [9:0]  op_en;
    logic        a_sel, b_sel, c_sel;
    logic [3:0]  a_reg, b_reg, c_reg;
    logic        illegal_op;
    logic [3:0]  phase;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;

    typedef struct {
        logic [9:0]  en;
        logic [2:0]  sel;   // {a,b,c}
        logic [11:0] regs;  // {c,b,a}
        logic        ill;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    cw_sequencer i_cw_sequencer (
        .clk(clk), .rst(rst), .host_strobe(host_strobe), .unit_busy(unit_busy),
        .ctrl_word(ctrl_word), .op_en(op_en), .a_sel(a_sel), .b_sel(b_sel),
        .c_sel(c_sel), .a_reg(a_reg), .b_reg(b_reg), .c_reg(c_reg),
        .illegal_op(illegal_op), .phase(phase)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic exp_t idle_item(input string tag);
        exp_t e;
        e.en = '0; e.sel = '0; e.regs = '0; e.ill = 1'b0; e.tag = tag;
        return e;
    endfunction

    function automatic exp_t model(input logic stb, input logic [31:0] w);
        exp_t e;
        int idx;
        logic [2:0] s;
        e = idle_item("R5 strobe-low idle");
        idx = -2;
        s = 3'b000;
        if (!stb) return e;
        case (w[23:16])
            8'h00: idx = -1;
            8'h04: begin idx = 0; s = 3'b101; end
            8'h08: begin idx = 1; s = 3'b111; end
            8'h0C: begin idx = 2; s = 3'b101; end
            8'h10: begin idx = 3; s = 3'b111; end
            8'h18: begin idx = 4; s = 3'b111; end
            8'h1C: begin idx = 5; s = 3'b111; end
            8'h30: begin idx = 6; s = 3'b101; end
            8'h34: begin idx = 7; s = 3'b101; end
            8'h38: begin idx = 8; s = 3'b001; end
            8'h3C: begin idx = 9; s = 3'b100; end
            default: idx = -2;
        endcase
        if (idx == -2 || w[31:24] != 0 || w[15:12] != 0) begin
            e.ill = 1'b1;
            e.tag = "R9 illegal word";
        end else if (idx == -1) begin
            e.tag = "R10 legal nop";
        end else begin
            e.en[idx] = 1'b1;
            e.sel = s;
            e.regs[3:0]  = s[2] ? w[3:0]  : 4'h0;
            e.regs[7:4]  = s[1] ? w[7:4]  : 4'h0;
            e.regs[11:8] = s[0] ? w[11:8] : 4'h0;
            e.tag = "R6 R7 R8 decode";
        end
        return e;
    endfunction

    // Monitor: phase sequencing and held-output scoreboard
    initial begin
        exp_t cur;
        logic [3:0] prev;
        logic [3:0] exp_ph;
        cur = idle_item("R4 R5 first period");
        prev = 4'b0001;
        wait (mon_on);
        forever begin
            @(negedge clk);
            exp_ph = (prev == 4'b0010 && unit_busy) ? 4'b0010 : {prev[2:0], prev[3]};
            chk(phase === exp_ph, (prev == 4'b0010) ? "R3 phase-2 hold" : "R2 phase step",
                {28'h0, phase}, {28'h0, exp_ph});
            if (phase === 4'b0001) begin
                if (exp_q.size() > 0) cur = exp_q.pop_front();
                else cur = idle_item("R5 no strobe");
            end
            chk({op_en, a_sel, b_sel, c_sel, c_reg, b_reg, a_reg, illegal_op} ===
                {cur.en, cur.sel, cur.regs, cur.ill},
                {cur.tag, " R4 held"},
                {6'h0, op_en, a_sel, b_sel, c_sel, c_reg, b_reg, a_reg, illegal_op},
                {6'h0, cur.en, cur.sel, cur.regs, cur.ill});
            prev = phase;
        end
    end

    // Driver: offers one word at a phase-4 boundary, then disturbs phases 1..3
    task automatic run_period(input logic stb, input logic [31:0] w,
                              input int hold_n, input logic noise);
        do @(negedge clk); while (phase !== 4'b1000);
        #1;
        host_strobe = stb;
        ctrl_word   = w;
        exp_q.push_back(model(stb, w));
        @(negedge clk); #1;
        host_strobe = noise;
        ctrl_word   = 32'h001C_0F0F;
        @(negedge clk); #1;
        if (hold_n > 0) begin
            unit_busy = 1'b1;
            for (int k = 0; k < hold_n; k++) begin
                @(negedge clk); #1;
            end
            unit_busy = 1'b0;
        end
        host_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(phase === 4'b0001, "R1 reset phase", {28'h0, phase}, 32'h1);
        chk(op_en === '0, "R1 reset enables", {22'h0, op_en}, 32'h0);
        chk({a_sel, b_sel, c_sel, illegal_op} === 4'b0, "R1 reset selects/illegal",
            {28'h0, a_sel, b_sel, c_sel, illegal_op}, 32'h0);
        chk({a_reg, b_reg, c_reg} === '0, "R1 reset register numbers",
            {20'h0, a_reg, b_reg, c_reg}, 32'h0);
        #1;
        rst = 1'b0;
        mon_on = 1'b1;

        run_period(1'b1, 32'h0038_0500, 0, 1'b0); // R6 R8 load: C only
        run_period(1'b1, 32'h003C_0007, 0, 1'b1); // R8 store: A only, R4 noise
        run_period(1'b1, 32'h0010_0321, 3, 1'b1); // R3 hold with R4 strobe collision
        run_period(1'b1, 32'h0018_0ABC, 0, 1'b0); // R7 fields
        run_period(1'b1, 32'h001C_0F12, 1, 1'b0);
        run_period(1'b1, 32'h0004_0404, 0, 1'b0);
        run_period(1'b1, 32'h0008_0626, 0, 1'b1);
        run_period(1'b1, 32'h000C_0909, 2, 1'b0);
        run_period(1'b1, 32'h0030_0D5E, 0, 1'b0); // R8 unused B nibble reads zero
        run_period(1'b1, 32'h0034_0102, 0, 1'b0);
        run_period(1'b1, 32'h0000_0000, 0, 1'b0); // R10
        run_period(1'b0, 32'h0038_0700, 0, 1'b1); // R5 strobe low
        run_period(1'b1, 32'h0014_0123, 0, 1'b0); // R9 unlisted opcode
        run_period(1'b1, 32'h0138_0100, 0, 1'b0); // R9 reserved high byte
        run_period(1'b1, 32'h0038_1100, 0, 1'b0); // R9 reserved nibble
        run_period(1'b1, 32'h0011_0000, 4, 1'b1); // R9 with hold
        run_period(1'b1, 32'h0010_0FED, 0, 1'b0);
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule